// File: doc/BRIEF.md
# Multiprocessor Interrupt Source Router

This block collects 32 level-sensitive device interrupt lines and turns them into one 16-bit priority-level vector per processor in a small multiprocessor system. Each input is brought into the clock domain through a two-flop synchronizer and then latched as a pending bit. Every source bit has a fixed interrupt level, given by an irregular table. Some table entries are level 0, and those sources are simply never latched.

Software controls delivery through five word-addressed 32-bit registers:
- a pending view;
- a disable view;
- separate enable (clear-disable) and disable (set-disable) strobes;
- a target-processor register.

Enabled device levels go only to the processor named by the target register. Any source on level 15 is broadcast to every processor. Each processor also has its own level-14 input, which reaches only that processor. One master-disable bit, bit 31 of the disable register, silences every device, broadcast and level-14 delivery. The level vectors feed per-processor combiners further downstream.

Top module: `irq_route_top`

## Requirements
- R1: An enabled pending source raises, on the target CPU's vector, the bit whose index is its level. The levels for source bits 0 to 31 are 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. Bit 0 of a vector is never set.
- R2: Sources 23 to 26 and 31 have level 0. They are never latched: their pending bits read 0 and they raise no level.
- R3: Offset 0 returns the pending sources, with bit 31 always 0. An input change is seen there, and on the vectors, after the third rising clock edge, and not after the second.
- R4: Offset 1 returns the disable register ANDed with the mask 0xf05dff80. It reads 0 after reset.
- R5: A write to offset 3 sets disable bits and a write to offset 2 clears them. Both writes affect only the bits in the mask 0xf05dff80. A disabled source raises no device level.
- R6: A write to offset 4 stores the low 4 bits of the data as the target CPU. A read of offset 4 returns that value. Reset selects CPU 0.
- R7: While disable bit 31 (master) is set, every vector reads all zero, including levels 14 and 15.
- R8: Device levels appear only on the CPU whose index equals the target. A target of NCPU or more delivers device levels to no CPU.
- R9: While any level-15 source (bits 27 to 30) is pending, bit 15 is set on every CPU's vector. This holds whatever the target and whatever the per-source disables. It clears when those sources drop.
- R10: The per-CPU timer input of CPU n sets bit 14 of CPU n's vector only. It passes through two synchronizer flops.
- R11: Reset loads the disable register with 0x0fa2007f. Sources 0 to 6, 17, 21 and 27 are therefore disabled for good, since no write can clear their bits.
- R12: Reads of offsets 5 to 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous level-sensitive device interrupt lines |
| timer_i | input | NCPU | Per-CPU level-14 inputs, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| lvl_o | output | NCPU*16 | Level vectors; CPU n in bits [16n+15:16n] |

## Verification
A wrong pending or disable bit shows up as a wrong level bit on the target vector. It appears in the same cycle the register holds the bad value, because the vectors are decoded combinationally from state. A synchronizer stage too many or too few moves that change one edge away from the third, and the pending read exposes this directly. A wrong target or a lost master bit shows as device levels on the wrong lane, or as levels that should be silent. Both are visible one cycle after the register write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int SRC_N     = 32;
    localparam int DATA_W    = 32;
    localparam int LVL_N     = 16;
    localparam int ADDR_W    = 3;
    localparam int TGT_W     = 4;
    localparam int MASTER_B  = 31;
    localparam int LVL_BCAST = 15;
    localparam int LVL_TIMER = 14;

    localparam logic [DATA_W-1:0] IMPL_MASK = 32'hf05dff80;
    localparam logic [DATA_W-1:0] DIS_RESET = ~IMPL_MASK;

    typedef enum logic [ADDR_W-1:0] {
        OFF_PEND   = 3'd0,
        OFF_DISRD  = 3'd1,
        OFF_ENABLE = 3'd2,
        OFF_DISSET = 3'd3,
        OFF_TARGET = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    function automatic logic [3:0] src_level(input int idx);
        logic [3:0] l;
        case (idx)
            0, 7:               l = 4'd2;
            1, 8:               l = 4'd3;
            2, 9:               l = 4'd5;
            3, 10:              l = 4'd7;
            4, 11, 21:          l = 4'd9;
            5, 12, 22:          l = 4'd11;
            6, 13, 17:          l = 4'd13;
            14, 15:             l = 4'd12;
            16:                 l = 4'd6;
            18:                 l = 4'd4;
            19:                 l = 4'd10;
            20:                 l = 4'd8;
            27, 28, 29, 30:     l = 4'd15;
            default:            l = 4'd0;
        endcase
        return l;
    endfunction

    function automatic logic [SRC_N-1:0] mapped_mask();
        logic [SRC_N-1:0] m;
        for (int i = 0; i < SRC_N; i++) m[i] = (src_level(i) != 4'd0);
        return m;
    endfunction

    function automatic logic [SRC_N-1:0] bcast_mask();
        logic [SRC_N-1:0] m;
        for (int i = 0; i < SRC_N; i++) m[i] = (src_level(i) == 4'(LVL_BCAST));
        return m;
    endfunction

    function automatic logic [LVL_N-1:0] levels_of(input logic [SRC_N-1:0] act);
        logic [LVL_N-1:0] v;
        v = '0;
        for (int i = 0; i < SRC_N; i++)
            if (act[i] && src_level(i) != 4'd0) v[src_level(i)] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> sync_q == $past(meta_q));
endmodule

// File: rtl/irq_pend.sv
module irq_pend
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_s,
    output logic [SRC_N-1:0] pend_q,
    output logic             bcast
);
    localparam logic [SRC_N-1:0] MAPPED = mapped_mask();
    localparam logic [SRC_N-1:0] BCAST  = bcast_mask();

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= src_s & MAPPED;
    end

    assign bcast = |(pend_q & BCAST);

    // R2: level-0 positions never hold a pending bit
    assert_unmapped_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~MAPPED) == '0);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [SRC_N-1:0]  pend,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dis_q,
    output logic [TGT_W-1:0]  tgt_q
);
    logic [DATA_W-1:0] wmask;

    assign wmask = req.data & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q <= DIS_RESET;
            tgt_q <= '0;
        end else if (req.we) begin
            case (req.addr)
                OFF_ENABLE: dis_q <= dis_q & ~wmask;
                OFF_DISSET: dis_q <= dis_q | wmask;
                OFF_TARGET: tgt_q <= req.data[TGT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (req.addr)
            OFF_PEND:   rdata = pend & ~(DATA_W'(1) << MASTER_B);
            OFF_DISRD:  rdata = dis_q & IMPL_MASK;
            OFF_TARGET: rdata = DATA_W'(tgt_q);
            default:    rdata = '0;
        endcase
    end

    assert_pend_bit31_R3: assert property (@(posedge clk) disable iff (rst)
        req.addr == OFF_PEND |-> !rdata[MASTER_B]);

    assert_disset_R5: assert property (@(posedge clk) disable iff (rst)
        req.we && req.addr == OFF_DISSET |=>
        (dis_q & $past(req.data & IMPL_MASK)) == $past(req.data & IMPL_MASK));

    assert_enable_R5: assert property (@(posedge clk) disable iff (rst)
        req.we && req.addr == OFF_ENABLE |=>
        (dis_q & $past(req.data & IMPL_MASK)) == '0);

    assert_fixed_disabled_R11: assert property (@(posedge clk) disable iff (rst)
        (dis_q & ~IMPL_MASK) == DIS_RESET);

    assert_target_wr_R6: assert property (@(posedge clk) disable iff (rst)
        req.we && req.addr == OFF_TARGET |=> tgt_q == $past(req.data[TGT_W-1:0]));

    assert_unmapped_wr_R12: assert property (@(posedge clk) disable iff (rst)
        req.we && req.addr > OFF_TARGET |=> $stable(dis_q) && $stable(tgt_q));
endmodule

// File: rtl/irq_lane.sv
module irq_lane
    import irq_route_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [LVL_N-1:0] dev_lvl,
    input  logic [TGT_W-1:0] tgt,
    input  logic             master_off,
    input  logic             bcast,
    input  logic             timer,
    output logic [LVL_N-1:0] lvl
);
    logic [LVL_N-1:0] routed;
    logic [LVL_N-1:0] local_lvl;

    always_comb begin
        routed = (tgt == TGT_W'(IDX)) ? dev_lvl : '0;
        local_lvl = '0;
        local_lvl[LVL_BCAST] = bcast;
        local_lvl[LVL_TIMER] = timer;
        lvl = master_off ? '0 : (routed | local_lvl);
        lvl[0] = 1'b0;
    end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SRC_N-1:0]        src_i,
    input  logic [NCPU-1:0]         timer_i,
    input  logic                    reg_we_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [DATA_W-1:0]       reg_wdata_i,
    output logic [DATA_W-1:0]       reg_rdata_o,
    output logic [NCPU*LVL_N-1:0]   lvl_o
);
    logic [SRC_N-1:0]  src_s;
    logic [NCPU-1:0]   timer_s;
    logic [SRC_N-1:0]  pend;
    logic              bcast;
    logic [DATA_W-1:0] dis;
    logic [TGT_W-1:0]  tgt;
    logic [LVL_N-1:0]  dev_lvl;
    reg_req_t          req;

    assign req = '{we: reg_we_i, addr: reg_addr_i, data: reg_wdata_i};

    irq_sync #(.W(SRC_N)) u_src_sync (
        .clk(clk), .rst(rst), .d(src_i), .q(src_s));

    irq_sync #(.W(NCPU)) u_tmr_sync (
        .clk(clk), .rst(rst), .d(timer_i), .q(timer_s));

    irq_pend u_pend (
        .clk(clk), .rst(rst), .src_s(src_s), .pend_q(pend), .bcast(bcast));

    irq_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .pend(pend),
        .rdata(reg_rdata_o), .dis_q(dis), .tgt_q(tgt));

    assign dev_lvl = levels_of(pend & ~dis);

    for (genvar c = 0; c < NCPU; c++) begin : g_lane
        irq_lane #(.IDX(c)) u_lane (
            .dev_lvl(dev_lvl), .tgt(tgt), .master_off(dis[MASTER_B]),
            .bcast(bcast), .timer(timer_s[c]),
            .lvl(lvl_o[c*LVL_N +: LVL_N]));

        assert_nontarget_R8: assert property (@(posedge clk) disable iff (rst)
            tgt != TGT_W'(c) |->
            (lvl_o[c*LVL_N +: LVL_N] & ~(LVL_N'(3) << LVL_TIMER)) == '0);

        assert_bit0_clear_R1: assert property (@(posedge clk) disable iff (rst)
            !lvl_o[c*LVL_N]);

        assert_bcast_all_R9: assert property (@(posedge clk) disable iff (rst)
            bcast && !dis[MASTER_B] |-> lvl_o[c*LVL_N + LVL_BCAST]);
    end

    assert_master_off_R7: assert property (@(posedge clk) disable iff (rst)
        dis[MASTER_B] |-> lvl_o == '0);
endmodule

// File: tb/test_irq_route_top.sv
module test_irq_route_top;
    localparam int NCPU = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        src_i = '0;
    logic [NCPU-1:0]    timer_i = '0;
    logic               reg_we_i = 1'b0;
    logic [2:0]         reg_addr_i = '0;
    logic [31:0]        reg_wdata_i = '0;
    logic [31:0]        reg_rdata_o;
    logic [NCPU*16-1:0] lvl_o;

    irq_route_top #(.NCPU(NCPU)) i_irq_route_top (
        .clk(clk), .rst(rst), .src_i(src_i), .timer_i(timer_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .lvl_o(lvl_o));

    always #5 clk = ~clk;

    typedef struct {
        string       tag;
        logic [31:0] exp;
        logic [31:0] act;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            it = q.pop_front();
            n_chk++;
            if (it.act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, it.act, it.exp);
            end
        end
    end

    task automatic push(input string tag, input logic [31:0] exp, input logic [31:0] act);
        q.push_back('{tag: tag, exp: exp, act: act});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        step(1);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr_i = a;
        #1;
        push(tag, exp, reg_rdata_o);
    endtask

    task automatic lane(input string tag, input int c, input logic [15:0] exp);
        push(tag, {16'h0, exp}, {16'h0, lvl_o[c*16 +: 16]});
    endtask

    task automatic lanes(input string tag, input logic [15:0] e0, input logic [15:0] e1,
                         input logic [15:0] e2, input logic [15:0] e3);
        lane(tag, 0, e0); lane(tag, 1, e1); lane(tag, 2, e2); lane(tag, 3, e3);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // reset state
        rd("R4 reset disable read", 3'd1, 32'h0);
        rd("R6 reset target", 3'd4, 32'h0);
        rd("R3 reset pending", 3'd0, 32'h0);
        lanes("R7 reset vectors", 16'h0, 16'h0, 16'h0, 16'h0);

        // R11: source 0 latched but stuck disabled
        src_i = 32'h1;
        step(3);
        rd("R11 src0 pending", 3'd0, 32'h1);
        lane("R11 src0 blocked", 0, 16'h0);
        wr(3'd2, 32'h1);
        lane("R11 src0 still blocked", 0, 16'h0);
        rd("R11 disable read", 3'd1, 32'h0);

        // R2: level-0 sources never latched
        src_i = 32'h8780_0000;
        step(3);
        rd("R2 unmapped pending", 3'd0, 32'h0);
        lanes("R2 unmapped vectors", 16'h0, 16'h0, 16'h0, 16'h0);

        // R3 timing + R1 map: src 7,18,20 -> levels 2,4,8
        src_i = 32'h0014_0080;
        step(2);
        rd("R3 not yet after two edges", 3'd0, 32'h0);
        step(1);
        rd("R3 pending after three edges", 3'd0, 32'h0014_0080);
        lanes("R1 target cpu0 levels", 16'h0114, 16'h0, 16'h0, 16'h0);

        // R5 per-source disable
        wr(3'd3, 32'h80);
        lane("R5 src7 disabled", 0, 16'h0110);
        rd("R5 disable readback", 3'd1, 32'h80);
        wr(3'd2, 32'h80);
        lane("R5 src7 enabled", 0, 16'h0114);

        // R4/R5/R7 full set, master
        wr(3'd3, 32'hffff_ffff);
        rd("R4 masked disable read", 3'd1, 32'hf05d_ff80);
        lanes("R7 master blocks", 16'h0, 16'h0, 16'h0, 16'h0);
        wr(3'd2, 32'h7fff_ffff);
        rd("R5 only master left", 3'd1, 32'h8000_0000);
        lane("R7 master still blocks", 0, 16'h0);
        wr(3'd2, 32'h8000_0000);
        rd("R5 all clear", 3'd1, 32'h0);
        lane("R7 master released", 0, 16'h0114);

        // R6/R8 target
        wr(3'd4, 32'h12);
        rd("R6 target low bits", 3'd4, 32'h2);
        lanes("R8 routed to cpu2", 16'h0, 16'h0, 16'h0114, 16'h0);
        wr(3'd4, 32'h7);
        rd("R6 target 7", 3'd4, 32'h7);
        lanes("R8 target out of range", 16'h0, 16'h0, 16'h0, 16'h0);

        // R9 broadcast
        src_i = 32'h1014_0080;
        step(3);
        lanes("R9 broadcast all", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        wr(3'd3, 32'h1000_0000);
        lanes("R9 broadcast ignores disable", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        wr(3'd4, 32'h1);
        lanes("R9 broadcast plus target", 16'h8000, 16'h8114, 16'h8000, 16'h8000);
        wr(3'd2, 32'h1000_0000);
        lane("R1 level15 via target", 1, 16'h8114);

        // R10 timer
        timer_i = 4'b1000;
        step(1);
        lane("R10 timer one edge", 3, 16'h8000);
        step(1);
        lanes("R10 timer cpu3", 16'h8000, 16'h8114, 16'h8000, 16'hc000);

        // R7 master blocks 14/15
        wr(3'd3, 32'h8000_0000);
        lanes("R7 master blocks 14 and 15", 16'h0, 16'h0, 16'h0, 16'h0);
        rd("R7 master readback", 3'd1, 32'h8000_0000);
        wr(3'd2, 32'h8000_0000);
        lane("R7 master reopened", 3, 16'hc000);

        // R9 release
        src_i = 32'h0;
        step(3);
        lanes("R9 broadcast cleared", 16'h0, 16'h0, 16'h0, 16'h4000);

        // R12 unmapped offsets
        rd("R12 read off5", 3'd5, 32'h0);
        rd("R12 read off6", 3'd6, 32'h0);
        rd("R12 read off7", 3'd7, 32'h0);
        wr(3'd5, 32'hffff_ffff);
        wr(3'd6, 32'hffff_ffff);
        wr(3'd7, 32'hffff_ffff);
        rd("R12 disable unchanged", 3'd1, 32'h0);
        rd("R12 target unchanged", 3'd4, 32'h1);
        lane("R12 vectors unchanged", 3, 16'h4000);

        wr(3'd4, 32'hffff_fff3);
        rd("R6 wide target write", 3'd4, 32'h3);

        step(2);
        wait (q.size() == 0);
        step(1);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule